// File: doc/BRIEF.md
# UART Register Front End

This block is the register-side half of a simple serial port. A 32-bit, word-only register bus reaches a status word, a one-entry receive holding register, an interrupt flag word with separate set and clear aliases, an interrupt enable word and a transmit data port. The bit-level serializer, the deserializer and the baud logic sit outside. Received bytes arrive as single-cycle pulses on `rx_valid`/`rx_byte`, and a line break arrives as a pulse on `rx_break`. Writes to the transmit port leave as a one-cycle pulse on `tx_valid` carrying the byte.

The receive holder is a two-state machine. The states are `RX_EMPTY` and `RX_HELD`, and four transitions connect them:
- CAPTURE (`RX_EMPTY` to `RX_HELD`) takes a byte or a break.
- DRAIN (`RX_HELD` to `RX_EMPTY`) follows a read of the receive word when no break arrives in the same cycle.
- OVERWRITE (`RX_HELD` to `RX_HELD`) loads a break over a word that is still held.
- REFILL (the return to `RX_HELD` in the cycle of a read) applies when a break and a read coincide.

The flag that mirrors "word held" and the receive interrupt are derived again on every clock edge. The transmit interrupt output is tied inactive.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the status word reads 0x0000_0040. The flag word, the enable word and the receive word read 0. `rx_ready` is 1, and `rx_irq`, `tx_irq` and `tx_valid` are 0.
- R2: The status word sits at offset 0x10. Its bit 6 (transmit buffer level) is always 1. Bit 7 (receive word valid) and bit 8 (receive full, since the holder has one entry) are 1 exactly when a word is held. All other bits are 0.
- R3: `rx_ready` is the inverse of the held state. A byte pulse is stored only while `rx_ready` is 1, and it then reads back in bits 7:0 of the receive word at offset 0x18. A byte offered while a word is held is dropped, and the held word is unchanged.
- R4: A read of offset 0x18 returns the held word and empties the holder from the next cycle on. A receive event in the same cycle as such a read wins, and the holder stays full with the new word.
- R5: A break pulse fills the holder whether or not it was empty, and the stored word is 0x0000_8000 (bit 15, framing error). A break beats a byte in the same cycle.
- R6: Bit 2 of the flag word equals the held state after every clock edge, whatever is written through the set and clear aliases.
- R7: A write to offset 0x44 ORs the write data into the flag word. A write to offset 0x48 clears the flag bits that are 1 in the write data. The flag word reads at offset 0x40.
- R8: A write to offset 0x4C replaces the enable word, which reads back at the same offset.
- R9: `rx_irq` is 1 exactly when flag bit 2 and enable bit 2 are both 1. `tx_irq` is always 0.
- R10: A write to offset 0x34 produces `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits 7:0 of the write data.
- R11: Reads of 0x0C, 0x34, any offset that is not a multiple of 4, and any offset outside the decoded set return 0. Writes to those offsets change no readable state. `bus_rdata` is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| rx_valid | input | 1 | Received byte pulse |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break event pulse |
| rx_ready | output | 1 | Holder empty, byte accepted |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt, held at 0 |

## Verification
The bench builds the block with its default 8-bit offset, 32-bit word and 8-bit byte parameters. The 8-bit offset space puts misaligned offsets and offsets past the decoded window within reach, alongside the decoded registers. Random traffic mixes breaks, bytes offered while the holder is full, and reads that coincide with receive events. This drives every holder transition, including OVERWRITE and REFILL, and exercises the flag aliases fighting the mirrored bit 2.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
    localparam int OFF_CMD    = 'h0C;
    localparam int OFF_STATUS = 'h10;
    localparam int OFF_RXWORD = 'h18;
    localparam int OFF_TXPORT = 'h34;
    localparam int OFF_FLAGS  = 'h40;
    localparam int OFF_FSET   = 'h44;
    localparam int OFF_FCLR   = 'h48;
    localparam int OFF_ENABLE = 'h4C;

    localparam int ST_TXLVL_BIT = 6;
    localparam int ST_VALID_BIT = 7;
    localparam int ST_FULL_BIT  = 8;
    localparam int FLAG_RX_BIT  = 2;
    localparam int FERR_BIT     = 15;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_HELD  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_break,
    input  logic              pop,
    output logic              ready,
    output logic              held,
    output logic              held_nxt,
    output logic [DATA_W-1:0] word
);
    localparam logic [DATA_W-1:0] BREAK_WORD = DATA_W'(1) << FERR_BIT;

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] word_q, word_d;

    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        unique case (state_q)
            RX_EMPTY: begin
                if (in_break) begin
                    state_d = RX_HELD;            // CAPTURE
                    word_d  = BREAK_WORD;
                end else if (in_valid) begin
                    state_d = RX_HELD;            // CAPTURE
                    word_d  = DATA_W'(in_byte);
                end
            end
            RX_HELD: begin
                if (in_break) begin
                    state_d = RX_HELD;            // OVERWRITE or REFILL
                    word_d  = BREAK_WORD;
                end else if (pop) begin
                    state_d = RX_EMPTY;           // DRAIN
                end
            end
            default: state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        ready    = (state_q == RX_EMPTY);
        held     = (state_q == RX_HELD);
        held_nxt = (state_d == RX_HELD);
        word     = word_q;
    end

    // R3: an accepted byte is held next cycle with its value
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && !in_break) |=> (held && word == DATA_W'($past(in_byte))));
    // R4: a read with no event empties the holder
    a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !in_break && !(in_valid && ready)) |=> !held);
    // R5: a break always leaves the framing-error word
    a_r5_break: assert property (@(posedge clk) disable iff (!rst_n)
        in_break |=> (held && word == BREAK_WORD));
    // R3: a byte offered while full leaves the word unchanged
    a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !pop && !in_break) |=> (held && $stable(word)));
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
    import uart_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              held,
    input  logic              held_nxt,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] enables,
    output logic              irq
);
    logic [DATA_W-1:0] flags_q, flags_d, en_q;

    always_comb begin
        flags_d = flags_q;
        if (wr_set) flags_d = flags_d | wdata;
        if (wr_clr) flags_d = flags_d & ~wdata;
        flags_d[FLAG_RX_BIT] = held_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= flags_d;
            if (wr_en) en_q <= wdata;
        end
    end

    always_comb begin
        flags   = flags_q;
        enables = en_q;
        irq     = flags_q[FLAG_RX_BIT] & en_q[FLAG_RX_BIT];
    end

    // R6: flag bit 2 tracks the holder state kept in another module
    a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_RX_BIT] == held);
    // R8: an enable write is visible next cycle
    a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (enables == $past(wdata)));
endmodule

// File: rtl/uart_tx_port.sv
module uart_tx_port #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_tx,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    logic              vld_q;
    logic [BYTE_W-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= wr_tx;
            if (wr_tx) dat_q <= wbyte;
        end
    end

    assign tx_valid = vld_q;
    assign tx_data  = dat_q;

    // R10: each pulse comes from a transmit write one cycle earlier
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> (tx_valid && tx_data == $past(wbyte)));
    a_r10_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tx |=> !tx_valid);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              rx_irq,
    output logic              tx_irq
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int ALIGN_W    = $clog2(WORD_BYTES);

    logic              aligned, rd, wr;
    logic              held, held_nxt;
    logic [DATA_W-1:0] rx_word, flags, enables, status;

    assign aligned = (bus_addr[ALIGN_W-1:0] == '0);
    assign rd      = bus_sel && !bus_wr && aligned;
    assign wr      = bus_sel &&  bus_wr && aligned;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    uart_rx_hold #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .in_break (rx_break),
        .pop      (rd && hit(bus_addr, OFF_RXWORD)),
        .ready    (rx_ready),
        .held     (held),
        .held_nxt (held_nxt),
        .word     (rx_word)
    );

    uart_irq_flags #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_set   (wr && hit(bus_addr, OFF_FSET)),
        .wr_clr   (wr && hit(bus_addr, OFF_FCLR)),
        .wr_en    (wr && hit(bus_addr, OFF_ENABLE)),
        .wdata    (bus_wdata),
        .held     (held),
        .held_nxt (held_nxt),
        .flags    (flags),
        .enables  (enables),
        .irq      (rx_irq)
    );

    uart_tx_port #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_tx    (wr && hit(bus_addr, OFF_TXPORT)),
        .wbyte    (bus_wdata[BYTE_W-1:0]),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    always_comb begin
        status               = '0;
        status[ST_TXLVL_BIT] = 1'b1;
        status[ST_VALID_BIT] = held;
        status[ST_FULL_BIT]  = held;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if      (hit(bus_addr, OFF_STATUS)) bus_rdata = status;
            else if (hit(bus_addr, OFF_RXWORD)) bus_rdata = rx_word;
            else if (hit(bus_addr, OFF_FLAGS))  bus_rdata = flags;
            else if (hit(bus_addr, OFF_ENABLE)) bus_rdata = enables;
        end
    end

    assign tx_irq = 1'b0;

    // R2: transmit level bit is set whenever status is read
    a_r2_txlvl: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit(bus_addr, OFF_STATUS)) |-> bus_rdata[ST_TXLVL_BIT]);
    // R9: receive interrupt agrees with readable flag and enable words
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (flags[FLAG_RX_BIT] && enables[FLAG_RX_BIT]));
    // R11: no read means zero read data
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (bus_rdata == '0));
endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, rx_irq, tx_irq;
    logic [7:0]  tx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfront dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    int n_cmp = 0, n_bad = 0;
    logic        m_held = 0, m_txv = 0;
    logic [31:0] m_word = 0, m_flags = 0, m_en = 0;
    logic [7:0]  m_txd = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic sel, input logic w, input logic [7:0] a);
        if (!sel || w || a[1:0] != 0) return 0;
        case (a)
            8'h10: return 32'h40 | (32'(m_held) << 7) | (32'(m_held) << 8);
            8'h18: return m_word;
            8'h40: return m_flags;
            8'h4C: return m_en;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h10: return "R2";
            8'h18: return "R4";
            8'h40: return "R7";
            8'h4C: return "R8";
            default: return "R11";
        endcase
    endfunction

    // drive one cycle, check outputs before the edge, update the model after it
    task automatic cyc(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic rv, input logic [7:0] rb, input logic brk);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_byte = rb; rx_break = brk;
        #1;
        e = exp_rd(s, w, a);
        chk(bus_rdata == e, tag_of(a), bus_rdata, e);
        chk(rx_ready == !m_held, "R3", 32'(rx_ready), 32'(!m_held));
        chk(rx_irq == (m_flags[2] & m_en[2]), "R9", 32'(rx_irq), 32'(m_flags[2] & m_en[2]));
        chk(tx_irq == 1'b0, "R9", 32'(tx_irq), 0);
        chk(tx_valid == m_txv, "R10", 32'(tx_valid), 32'(m_txv));
        if (m_txv) chk(tx_data == m_txd, "R10", 32'(tx_data), 32'(m_txd));
        @(posedge clk);
        begin
            logic nh = m_held;
            logic al = (a[1:0] == 0);
            if (s && !w && al && a == 8'h18) nh = 0;
            if (brk) begin nh = 1; m_word = 32'h8000; end
            else if (rv && !m_held) begin nh = 1; m_word = 32'(rb); end
            if (s && w && al && a == 8'h44) m_flags = m_flags | d;
            if (s && w && al && a == 8'h48) m_flags = m_flags & ~d;
            m_flags[2] = nh;
            if (s && w && al && a == 8'h4C) m_en = d;
            m_txv = s && w && al && a == 8'h34;
            if (m_txv) m_txd = d[7:0];
            m_held = nh;
        end
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] alist [12];
        void'($urandom(1234));
        alist = '{8'h0C, 8'h10, 8'h18, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h12, 8'h19, 8'h80};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(1, 0, 8'h10, 0, 0, 0, 0);
        cyc(1, 0, 8'h40, 0, 0, 0, 0);
        cyc(1, 0, 8'h4C, 0, 0, 0, 0);
        cyc(1, 0, 8'h18, 0, 0, 0, 0);
        chk(m_word == 0 && m_flags == 0, "R1", m_flags, 0);
        // R3 byte capture, R9 irq with enable
        cyc(1, 1, 8'h4C, 32'h4, 8'h1, 8'hA5, 0);
        cyc(1, 0, 8'h40, 0, 0, 0, 0);
        // R3 byte dropped while held
        cyc(0, 0, 0, 0, 1, 8'h3C, 0);
        // R6 clear alias cannot drop bit 2 while held
        cyc(1, 1, 8'h48, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 0, 8'h40, 0, 0, 0, 0);
        // R4 read empties, then R6 set alias cannot raise bit 2
        cyc(1, 0, 8'h18, 0, 0, 0, 0);
        cyc(1, 1, 8'h44, 32'h0000_0F0F, 0, 0, 0);
        cyc(1, 0, 8'h40, 0, 0, 0, 0);
        // R4 byte in the cycle of a read while empty, then R5 break + read (REFILL)
        cyc(1, 0, 8'h18, 0, 1, 8'h77, 0);
        cyc(1, 0, 8'h18, 0, 0, 0, 1);
        cyc(1, 0, 8'h18, 0, 0, 0, 0);
        // R5 break while empty beats byte; OVERWRITE while held
        cyc(0, 0, 0, 0, 1, 8'h11, 1);
        cyc(0, 0, 0, 0, 1, 8'h22, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 8'h18, 0, 0, 0, 0);
        // R10 transmit pulse
        cyc(1, 1, 8'h34, 32'hDEAD_BE5A, 0, 0, 0);
        idle();
        idle();
        // R11 writes to command / misaligned / outside change nothing
        cyc(1, 1, 8'h0C, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 1, 8'h4D, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 1, 8'h50, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 0, 8'h4C, 0, 0, 0, 0);
        cyc(1, 0, 8'h34, 0, 0, 0, 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            logic [7:0] a = alist[$urandom % 12];
            logic [31:0] d = $urandom;
            cyc(r[0] | r[1], r[2], a, d, r[3] & r[4], 8'($urandom), (r[7:5] == 0));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule